// File: doc/BRIEF.md
# Secure Stage-2 Translation Control Register

This block holds the 64-bit control word that configures the second translation stage for the secure guest regime, and gates every software access to it. Each request carries the requester's privilege level (0 to 3), a non-secure state flag, a flag saying the hypervisor level is enabled, and the two nested-virtualization control bits. In the same cycle the block answers with exactly one outcome: the access completes, it is undefined, it traps to the hypervisor level with a fixed exception class, or it is redirected to a fixed offset in a memory-backed save area. A completed write takes effect on the next clock edge.

Only the writable fields are stored. Reserved bits read back at fixed values whatever was written. From the stored fields the block continuously derives what a page-table walker needs: the effective output address space, the walk address space, the granule size, the starting lookup level, the log2 of the input region size, and a flag for a configuration that must cause a level-0 translation fault. The walk itself, and the save area behind redirected accesses, are outside this block.

Top module: `s2tc_reg`

## Requirements
- R1: A read returns 0 in bits 63:32, 28:16 and 13:8 and 1 in bit 31, whatever was written to those bits.
- R2: Bit 30 (output space) and bit 29 (walk space) are stored and read back as written; `pa_ns_o` is 1 when either stored bit is 1, and `walk_ns_o` equals stored bit 29.
- R3: Bits 15:14 select the granule, 00 = 4KB, 01 = 64KB, 10 = 16KB, and 11 acts as 4KB; `gran_o` encodes 0 = 4KB, 1 = 16KB, 2 = 64KB; readback returns the programmed code, including 11.
- R4: Bits 7:6 select the start level: with a 4KB granule codes 00/01/10/11 give `level_o` 2/1/0/3; with a 16KB or 64KB granule codes 00/01/10 give 3/2/1, and code 11 is reserved and reports level 0.
- R5: `cfg_fault_o` is 1 when the start-level code is reserved, or when the input width W = 64 − size lies outside g + (n−1)(g−3) + 1 ≤ W ≤ g + n(g−3), where g is 12/14/16 for 4KB/16KB/64KB and n = 4 − level.
- R6: Bits 5:0 hold the size field and `region_log2_o` equals 64 minus that field.
- R7: A valid access at privilege level 0 is undefined; at level 3 it completes. Every valid request has exactly one outcome.
- R8: At privilege level 2 the access is undefined when the non-secure flag is 1, and completes otherwise.
- R9: At level 1 with the hypervisor level enabled and both nested bits set, the access is redirected with offset 0x048; with the hypervisor level enabled and only the primary nested bit set it is undefined when non-secure and otherwise traps with class 0x18; every other level-1 access is undefined.
- R10: Only a write that completes changes the stored fields; reset clears every writable field to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_el | input | 2 | Privilege level of the requester |
| req_ns | input | 1 | Requester is in non-secure state |
| req_hyp_en | input | 1 | Hypervisor level enabled in current state |
| req_nest | input | 1 | Primary nested-virtualization bit |
| req_nest_mem | input | 1 | Nested redirect-to-memory bit |
| req_wdata | input | 64 | Write data |
| rsp_rdata | output | 64 | Read data (0 unless a read completes) |
| rsp_done | output | 1 | Access completed on the register |
| rsp_undef | output | 1 | Access is undefined |
| rsp_trap | output | 1 | Access traps to the hypervisor level |
| rsp_trap_class | output | 6 | Exception class of the trap (0x18 when trapping) |
| rsp_redirect | output | 1 | Access redirected to the save area |
| rsp_redirect_off | output | 12 | Save-area offset (0x048 when redirected) |
| pa_ns_o | output | 1 | Effective output address space is non-secure |
| walk_ns_o | output | 1 | Table walks go to non-secure space |
| gran_o | output | 2 | Effective granule (0 = 4KB, 1 = 16KB, 2 = 64KB) |
| level_o | output | 2 | Starting lookup level |
| region_log2_o | output | 7 | log2 of the input region size in bytes |
| cfg_fault_o | output | 1 | Inconsistent configuration, level-0 fault required |

## Verification
The hardest situation to reach is the edge of the size window for each granule and start level, together with the reserved granule and start-level codes, because only particular combinations of three fields land just inside or just outside it. The bench reaches it by writing every combination of granule code, start-level code and size value from the most privileged level, with reserved bits set to the opposite of their fixed values, and checking readback and every decoded output against arithmetic done in the bench. The access gate is swept over all 64 combinations of level and flags for both reads and writes, with a privileged readback after each write to catch a blocked write that changed state.

// File: rtl/s2tc_pkg.sv
// Shared types and helpers for the secure stage-2 control register.
// Assumes the stored fields are the only state; everything else is derived.
package s2tc_pkg;

    // Writable fields of the control word
    typedef struct packed {
        logic       out_ns;   // bit 30
        logic       walk_ns;  // bit 29
        logic [1:0] gcode;    // bits 15:14
        logic [1:0] lcode;    // bits 7:6
        logic [5:0] size;     // bits 5:0
    } cfg_t;

    // Effective granule encoding seen by the walker
    typedef enum logic [1:0] {
        GRAN_4K  = 2'd0,
        GRAN_16K = 2'd1,
        GRAN_64K = 2'd2
    } gran_e;

    // Outcome of an access request
    typedef enum logic [1:0] {
        ACC_DONE  = 2'd0,
        ACC_UNDEF = 2'd1,
        ACC_TRAP  = 2'd2,
        ACC_REDIR = 2'd3
    } acc_e;

    // Page-offset bit count of a granule
    function automatic logic [7:0] gran_bits(gran_e g);
        case (g)
            GRAN_16K: gran_bits = 8'd14;
            GRAN_64K: gran_bits = 8'd16;
            default:  gran_bits = 8'd12;
        endcase
    endfunction

endpackage

// File: rtl/s2tc_gate.sv
// Access-permission gate: classifies each request into exactly one outcome
// from privilege level, security state and the nested-virtualization bits.
// Assumes the request fields are stable while req_valid is high.
module s2tc_gate
    import s2tc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       valid,
    input  logic [1:0] el,
    input  logic       ns,
    input  logic       hyp_en,
    input  logic       nest,
    input  logic       nest_mem,
    output logic       done,
    output logic       undef,
    output logic       trap,
    output logic       redir
);

    acc_e outcome;

    // Decide the outcome of the request by privilege level
    always_comb begin
        outcome = ACC_UNDEF;
        case (el)
            2'd3: outcome = ACC_DONE;
            2'd2: outcome = ns ? ACC_UNDEF : ACC_DONE;
            2'd1: begin
                if (hyp_en && nest && nest_mem)
                    outcome = ACC_REDIR;
                else if (hyp_en && nest)
                    outcome = ns ? ACC_UNDEF : ACC_TRAP;
                else
                    outcome = ACC_UNDEF;
            end
            default: outcome = ACC_UNDEF;
        endcase
    end

    // Drive one-hot outcome flags only for a valid request
    always_comb begin
        done  = valid && (outcome == ACC_DONE);
        undef = valid && (outcome == ACC_UNDEF);
        trap  = valid && (outcome == ACC_TRAP);
        redir = valid && (outcome == ACC_REDIR);
    end

    p_one_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $countones({done, undef, trap, redir}) == 1);
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> !(done || undef || trap || redir));
    p_el0_undef_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && el == 2'd0) |-> undef);
    p_el2_ns_undef_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && el == 2'd2 && ns) |-> undef);
    p_trap_secure_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (!ns && el == 2'd1));

endmodule

// File: rtl/s2tc_store.sv
// Field storage and readback. Holds only the writable fields; reserved bits
// are produced as constants at readback. Assumes wr_en is already gated.
module s2tc_store
    import s2tc_pkg::*;
#(
    parameter int DATA_W = 64
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output cfg_t              cfg,
    output logic [DATA_W-1:0] rd_word
);

    localparam int HI_W = DATA_W - 32;

    // Capture writable fields on a permitted write, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            cfg.out_ns  <= wdata[30];
            cfg.walk_ns <= wdata[29];
            cfg.gcode   <= wdata[15:14];
            cfg.lcode   <= wdata[7:6];
            cfg.size    <= wdata[5:0];
        end
    end

    // Assemble the read word with reserved bits at fixed values
    always_comb begin
        rd_word = {{HI_W{1'b0}}, 1'b1, cfg.out_ns, cfg.walk_ns, 13'd0,
                   cfg.gcode, 6'd0, cfg.lcode, cfg.size};
    end

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg));

endmodule

// File: rtl/s2tc_decode.sv
// Derives walker-facing values from the stored fields: address spaces,
// effective granule, start level, region size and the consistency fault.
// Assumes a fixed 64-bit input address space.
module s2tc_decode
    import s2tc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cfg_t       cfg,
    output logic       pa_ns,
    output logic       walk_ns,
    output logic [1:0] gran,
    output logic [1:0] level,
    output logic [6:0] region_log2,
    output logic       fault
)
;

    gran_e      g;
    logic       lvl_rsvd;
    logic [7:0] width, gb, stride, nlev, hi_w, lo_w;

    // Resolve address spaces; walk space forces the output space
    always_comb begin
        walk_ns = cfg.walk_ns;
        pa_ns   = cfg.out_ns | cfg.walk_ns;
    end

    // Map the granule code, reserved code acting as 4KB
    always_comb begin
        case (cfg.gcode)
            2'b01:   g = GRAN_64K;
            2'b10:   g = GRAN_16K;
            default: g = GRAN_4K;
        endcase
        gran = g;
    end

    // Start level from code and granule
    always_comb begin
        lvl_rsvd = 1'b0;
        level    = 2'd0;
        if (g == GRAN_4K) begin
            case (cfg.lcode)
                2'b00:   level = 2'd2;
                2'b01:   level = 2'd1;
                2'b10:   level = 2'd0;
                default: level = 2'd3;
            endcase
        end else begin
            case (cfg.lcode)
                2'b00:   level = 2'd3;
                2'b01:   level = 2'd2;
                2'b10:   level = 2'd1;
                default: begin
                    level    = 2'd0;
                    lvl_rsvd = 1'b1;
                end
            endcase
        end
    end

    // Check the input width against the window walked from the start level
    always_comb begin
        width       = 8'd64 - {2'd0, cfg.size};
        region_log2 = width[6:0];
        gb          = gran_bits(g);
        stride      = gb - 8'd3;
        nlev        = 8'd4 - {6'd0, level};
        hi_w        = gb + nlev * stride;
        lo_w        = gb + (nlev - 8'd1) * stride + 8'd1;
        fault       = lvl_rsvd || (width > hi_w) || (width < lo_w);
    end

    p_rsvd_level_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.gcode inside {2'b01, 2'b10} && cfg.lcode == 2'b11) |-> fault);
    p_out_space_r2: assert property (@(posedge clk) disable iff (!rst_n)
        walk_ns |-> pa_ns);

endmodule

// File: rtl/s2tc_reg.sv
// Top: secure stage-2 translation control register with access gate.
// Read data is combinational in the request cycle; a completed write is
// visible from the following cycle. Assumes one request per cycle.
module s2tc_reg
    import s2tc_pkg::*;
#(
    parameter int          DATA_W    = 64,
    parameter logic [11:0] REDIR_OFF = 12'h048,
    parameter logic [5:0]  TRAP_EC   = 6'h18
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_el,
    input  logic              req_ns,
    input  logic              req_hyp_en,
    input  logic              req_nest,
    input  logic              req_nest_mem,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic              rsp_undef,
    output logic              rsp_trap,
    output logic [5:0]        rsp_trap_class,
    output logic              rsp_redirect,
    output logic [11:0]       rsp_redirect_off,
    output logic              pa_ns_o,
    output logic              walk_ns_o,
    output logic [1:0]        gran_o,
    output logic [1:0]        level_o,
    output logic [6:0]        region_log2_o,
    output logic              cfg_fault_o
);

    cfg_t              cfg;
    logic [DATA_W-1:0] rd_word;
    logic              wr_en;

    s2tc_gate gate_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (req_valid),
        .el       (req_el),
        .ns       (req_ns),
        .hyp_en   (req_hyp_en),
        .nest     (req_nest),
        .nest_mem (req_nest_mem),
        .done     (rsp_done),
        .undef    (rsp_undef),
        .trap     (rsp_trap),
        .redir    (rsp_redirect)
    );

    // Commit only writes the gate lets through
    always_comb wr_en = rsp_done && req_write;

    s2tc_store #(.DATA_W(DATA_W)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wdata   (req_wdata),
        .cfg     (cfg),
        .rd_word (rd_word)
    );

    s2tc_decode decode_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg         (cfg),
        .pa_ns       (pa_ns_o),
        .walk_ns     (walk_ns_o),
        .gran        (gran_o),
        .level       (level_o),
        .region_log2 (region_log2_o),
        .fault       (cfg_fault_o)
    );

    // Return data and side-band values only for the matching outcome
    always_comb begin
        rsp_rdata        = (rsp_done && !req_write) ? rd_word : '0;
        rsp_trap_class   = rsp_trap ? TRAP_EC : 6'd0;
        rsp_redirect_off = rsp_redirect ? REDIR_OFF : 12'd0;
    end

    p_trap_class_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap |-> rsp_trap_class == TRAP_EC);
    p_blocked_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !rsp_done) |=> $stable(cfg));

endmodule

// File: tb/s2tc_reg_tb.sv
module s2tc_reg_tb_top;

    localparam int CLK_P    = 10;
    localparam int WATCHDOG = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_el = 2'd0;
    logic        req_ns = 1'b0, req_hyp_en = 1'b0, req_nest = 1'b0, req_nest_mem = 1'b0;
    logic [63:0] req_wdata = '0;
    logic [63:0] rsp_rdata;
    logic        rsp_done, rsp_undef, rsp_trap, rsp_redirect;
    logic [5:0]  rsp_trap_class;
    logic [11:0] rsp_redirect_off;
    logic        pa_ns_o, walk_ns_o, cfg_fault_o;
    logic [1:0]  gran_o, level_o;
    logic [6:0]  region_log2_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    logic [63:0] model;   // expected readback word

    s2tc_reg dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_el(req_el), .req_ns(req_ns), .req_hyp_en(req_hyp_en),
        .req_nest(req_nest), .req_nest_mem(req_nest_mem), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .rsp_undef(rsp_undef),
        .rsp_trap(rsp_trap), .rsp_trap_class(rsp_trap_class),
        .rsp_redirect(rsp_redirect), .rsp_redirect_off(rsp_redirect_off),
        .pa_ns_o(pa_ns_o), .walk_ns_o(walk_ns_o), .gran_o(gran_o),
        .level_o(level_o), .region_log2_o(region_log2_o), .cfg_fault_o(cfg_fault_o)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            n_tests = n_tests + 1;
            n_fail  = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests = n_tests + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected readback word built from write data
    function automatic logic [63:0] pack(input logic [63:0] w);
        return {32'd0, 1'b1, w[30], w[29], 13'd0, w[15:14], 6'd0, w[7:6], w[5:0]};
    endfunction

    // Privileged read, result sampled after combinational settle
    task automatic rd3(output logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_el = 2'd3; req_ns = 1'b0;
        req_hyp_en = 1'b0; req_nest = 1'b0; req_nest_mem = 1'b0;
        #1 d = rsp_rdata;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wr3(input logic [63:0] w);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_el = 2'd3; req_ns = 1'b0;
        req_hyp_en = 1'b0; req_nest = 1'b0; req_nest_mem = 1'b0; req_wdata = w;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    initial begin
        logic [63:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state: writable fields cleared (R10), fixed bit 31 (R1)
        rd3(d);
        check("R10 reset readback", d, 64'h0000_0000_8000_0000);
        check("R6 reset region", {57'd0, region_log2_o}, 64'd64);
        check("R3 reset granule", {62'd0, gran_o}, 64'd0);
        model = 64'h0000_0000_8000_0000;

        // Access gate sweep over level, flags and direction (R7, R8, R9, R10)
        for (int i = 0; i < 128; i++) begin
            logic [1:0] el;
            logic ns, he, nv, nm, wr;
            logic e_done, e_undef, e_trap, e_redir;
            logic [63:0] w;
            el = i[1:0]; ns = i[2]; he = i[3]; nv = i[4]; nm = i[5]; wr = i[6];
            e_done = 0; e_undef = 0; e_trap = 0; e_redir = 0;
            if (el == 2'd3) e_done = 1;
            else if (el == 2'd2) begin
                if (ns) e_undef = 1; else e_done = 1;
            end else if (el == 2'd1) begin
                if (he && nv && nm) e_redir = 1;
                else if (he && nv) begin
                    if (ns) e_undef = 1; else e_trap = 1;
                end else e_undef = 1;
            end else e_undef = 1;
            w = {32'hA5A5_0000 | 32'(i), 1'b0, i[1], i[3], 13'h0AA, i[2:1], 6'h15, i[6:5], i[5:0]};
            @(negedge clk);
            req_valid = 1'b1; req_write = wr; req_el = el; req_ns = ns;
            req_hyp_en = he; req_nest = nv; req_nest_mem = nm; req_wdata = w;
            #1;
            check(el == 0 ? "R7 el0 undef" : el == 3 ? "R7 el3 done" :
                  el == 2 ? "R8 el2 outcome" : "R9 el1 outcome",
                  {60'd0, rsp_done, rsp_undef, rsp_trap, rsp_redirect},
                  {60'd0, e_done, e_undef, e_trap, e_redir});
            if (e_trap) check("R9 trap class", {58'd0, rsp_trap_class}, 64'h18);
            if (e_redir) check("R9 redirect offset", {52'd0, rsp_redirect_off}, 64'h048);
            if (!wr) check("R8 read data", rsp_rdata, e_done ? model : 64'd0);
            @(negedge clk);
            req_valid = 1'b0; req_write = 1'b0;
            if (wr) begin
                if (e_done) model = pack(w);
                rd3(d);
                check("R10 write gating", d, model);
            end
        end

        // Field sweep: granule x start level x size, reserved bits inverted
        for (int tg = 0; tg < 4; tg++) begin
            for (int sl = 0; sl < 4; sl++) begin
                for (int t = 0; t < 64; t++) begin
                    logic [63:0] w;
                    logic sa, sw, rsv, e_fault;
                    int g, lvl, width, n, hi, lo, ge;
                    sa = t[0]; sw = t[1];
                    w = {32'hFFFF_FFFF, 1'b0, sa, sw, 13'h1FFF, 2'(tg), 6'h3F, 2'(sl), 6'(t)};
                    wr3(w);
                    rd3(d);
                    check("R1 reserved bits fixed", d & 64'hFFFF_FFFF_9FFF_3F00, 64'h0000_0000_8000_0000);
                    check("R2 space bits readback", {62'd0, d[30], d[29]}, {62'd0, sa, sw});
                    check("R3 granule readback", {62'd0, d[15:14]}, 64'(tg));
                    check("R2 effective output space", {63'd0, pa_ns_o}, {63'd0, sa | sw});
                    check("R2 walk space", {63'd0, walk_ns_o}, {63'd0, sw});
                    // granule: 4KB code 0 or 3, 64KB code 1, 16KB code 2
                    ge = (tg == 1) ? 2 : (tg == 2) ? 1 : 0;
                    g  = (ge == 0) ? 12 : (ge == 1) ? 14 : 16;
                    check("R3 effective granule", {62'd0, gran_o}, 64'(ge));
                    rsv = 0;
                    if (ge == 0) lvl = (sl == 3) ? 3 : 2 - sl;
                    else if (sl == 3) begin lvl = 0; rsv = 1; end
                    else lvl = 3 - sl;
                    check("R4 start level", {62'd0, level_o}, 64'(lvl));
                    width = 64 - t;
                    check("R6 region size", {57'd0, region_log2_o}, 64'(width));
                    n  = 4 - lvl;
                    hi = g + n * (g - 3);
                    lo = g + (n - 1) * (g - 3) + 1;
                    e_fault = rsv || width > hi || width < lo;
                    check("R5 config fault", {63'd0, cfg_fault_o}, {63'd0, e_fault});
                end
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule